// File: doc/BRIEF.md
# Byte-Wide SPI Host Controller

This block is a register-driven SPI host that moves exactly one byte per write to its data register. A control register holds an enable bit, a two-bit speed field, a two-bit device field, a chip-select hold bit, an interrupt-enable bit and a read-only busy flag. A data write accepted while the host is enabled and idle starts an eight-bit full-duplex exchange in SPI mode 0, MSB first. When the eighth bit has been sampled, the received byte lands in the data register, busy drops, and a one-cycle interrupt pulse is raised if it is enabled.

The whole byte takes 2^(PERIOD_EXP − speed) system clocks, so each bit period is 2^(PERIOD_EXP − 3 − speed) clocks. With hold clear, chip select stays asserted for one more bit period after the last bit and then releases. With hold set, chip select stays asserted between bytes, so several bytes form one transaction. A control write made while hold was clear sends a one-cycle restart pulse to the device named in the new device field, so that the device can drop any half-finished command.

The controller is a four-state machine. ST_IDLE: chip select released, waiting for a data write. ST_SHIFT: the byte is moving and busy is set. ST_TAIL: the byte is done and chip select is held for one bit period. ST_HOLD: the byte is done and chip select is held until the next byte or until hold is cleared. The transitions are: IDLE→SHIFT on an accepted data write. SHIFT→TAIL at the end of the byte when hold is clear. SHIFT→HOLD at the end of the byte when hold is set. TAIL→IDLE when the bit period ends. TAIL→SHIFT on an accepted data write. HOLD→SHIFT on an accepted data write. HOLD→IDLE on a control write that clears hold.

Top module: `spi_byte_host`

## Requirements
- R1: While control bit 0 (enable) is clear, a write to the data register (wr_addr=1) is ignored: busy stays clear, data_q is unchanged, no chip select asserts and sclk stays low.
- R2: An accepted data write sets busy (control bit 7) in the next cycle. Busy stays set for exactly 2^(PERIOD_EXP − speed) clock cycles, where speed is control bits [2:1].
- R3: The exchange uses SPI mode 0 and sends MSB first. mosi carries the written byte, miso is sampled on each rising sclk edge, and at the end of the byte data_q holds the eight sampled bits, first sample in bit 7.
- R4: At the end of a byte, irq pulses high for one cycle if control bit 6 is set. Otherwise irq stays low.
- R5: Device field control bits [4:3] pick the chip select: 0 drives cs_n[0] low (power manager), 1 drives cs_n[1] low (firmware flash), 2 drives cs_n[2] low (touchscreen), and 3 selects none. At most one cs_n is low at any time.
- R6: With hold (control bit 5) clear, chip select stays low for one bit period, 2^(PERIOD_EXP − 3 − speed) cycles, after busy falls, and then goes high. A data write inside that window starts a new byte with chip select still low.
- R7: With hold set, chip select stays low after the byte and through the next byte. A control write that clears hold releases chip select in the next cycle.
- R8: A control write made while hold was clear pulses txn_rst for one cycle, on the bit of the device named in the newly written device field. No pulse is sent when hold was set.
- R9: Data and control writes that arrive while busy is set are dropped. Busy stays set, the control settings read back unchanged, and the byte in flight is not altered.
- R10: sclk is low whenever busy is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control register, 1 selects the data register |
| wr_data | input | 8 | Write data |
| ctrl_q | output | 8 | Control readback: {busy, irq_en, hold, device[1:0], speed[1:0], enable} |
| data_q | output | 8 | Last received byte |
| sclk | output | 1 | SPI clock (mode 0) |
| mosi | output | 1 | Host-to-device serial data |
| miso | input | 1 | Device-to-host serial data |
| cs_n | output | NDEV | Active-low chip selects, one per device |
| txn_rst | output | NDEV | One-cycle transaction restart pulse per device |
| irq | output | 1 | End-of-byte interrupt pulse |

## Verification
The bench measures the busy length and the chip-select tail at every speed setting. An off-by-one in the divider or in the half-bit count shows up there as a count that is one half-bit long or short. It writes during a transfer and during the tail window. A design that does not drop writes while busy would restart or corrupt the byte in flight, and one that does not restart from the tail would leave busy low or release chip select. Held transactions and the restart pulse are checked on each side of the hold bit, which catches a design that releases chip select between held bytes or pulses the restart on the wrong device. Random bytes against a device model catch bit-order and sampling-edge errors as a wrong mosi capture or a wrong data_q.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2,
        ST_HOLD  = 2'd3
    } spi_state_e;

    localparam int F_EN   = 0;
    localparam int F_BAUD = 1;
    localparam int F_DEV  = 3;
    localparam int F_HOLD = 5;
    localparam int F_IE   = 6;
    localparam int F_BUSY = 7;

    localparam int BAUD_W = 2;
    localparam int DEV_W  = 2;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int PERIOD_EXP = 19,
    parameter int BAUD_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    input  logic [BAUD_W-1:0] baud,
    output logic              half_tick
);
    localparam int CW   = PERIOD_EXP - 3;
    localparam int BASE = PERIOD_EXP - 4;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // half a bit period is 2^(BASE - baud) clocks
    always_comb lim = CW'((64'd1 << (BASE - int'(baud))) - 64'd1);

    assign half_tick = run && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (clr || !run || half_tick)  cnt_q <= '0;
        else                                cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       rise,
    input  logic       fall,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte
);
    logic [7:0] tx_q;
    logic [7:0] rx_q;
    logic       sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            rx_q   <= '0;
            sclk_q <= 1'b0;
        end else if (load) begin
            tx_q   <= load_byte;
            sclk_q <= 1'b0;
        end else if (rise) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso};
        end else if (fall) begin
            sclk_q <= 1'b0;
            tx_q   <= {tx_q[6:0], 1'b0};
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = tx_q[7];
    assign rx_byte = rx_q;
endmodule

// File: rtl/spi_dev_decode.sv
module spi_dev_decode #(
    parameter int NDEV = 3,
    parameter int SELW = 2
) (
    input  logic            en,
    input  logic [SELW-1:0] sel,
    output logic [NDEV-1:0] hit
);
    for (genvar i = 0; i < NDEV; i++) begin : g_hit
        assign hit[i] = en && (sel == SELW'(i));
    end
endmodule

// File: rtl/spi_byte_host.sv
module spi_byte_host
    import spi_host_pkg::*;
#(
    parameter int PERIOD_EXP = 19,
    parameter int NDEV       = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_addr,
    input  logic [7:0]      wr_data,
    output logic [7:0]      ctrl_q,
    output logic [7:0]      data_q,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso,
    output logic [NDEV-1:0] cs_n,
    output logic [NDEV-1:0] txn_rst,
    output logic            irq
);
    spi_state_e state_q, state_d;

    logic              en_q, hold_q, ie_q;
    logic [BAUD_W-1:0] baud_q;
    logic [DEV_W-1:0]  dev_q, act_dev_q, txn_dev_q;
    logic [3:0]        hcnt_q;
    logic              txn_v_q;
    logic              busy, ctrl_wr, data_go, half_tick, done;
    logic              rise, fall, tail_end, timer_run;
    logic [7:0]        rx_byte;
    logic [NDEV-1:0]   cs_hit;
    logic              unused_busy_bit;

    assign unused_busy_bit = wr_data[F_BUSY];

    assign busy      = (state_q == ST_SHIFT);
    assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL) && !busy;
    assign data_go   = wr_en && (wr_addr == ADDR_DATA) && en_q && !busy;
    assign rise      = busy && half_tick && !hcnt_q[0];
    assign fall      = busy && half_tick &&  hcnt_q[0];
    assign done      = fall && (hcnt_q == 4'd15);
    assign tail_end  = (state_q == ST_TAIL) && half_tick && hcnt_q[0];
    assign timer_run = (state_q == ST_SHIFT) || (state_q == ST_TAIL);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (data_go) state_d = ST_SHIFT;
            ST_SHIFT: if (done)    state_d = hold_q ? ST_HOLD : ST_TAIL;
            ST_TAIL: begin
                if (data_go)       state_d = ST_SHIFT;
                else if (tail_end) state_d = ST_IDLE;
            end
            ST_HOLD: begin
                if (data_go)                           state_d = ST_SHIFT;
                else if (ctrl_wr && !wr_data[F_HOLD])  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // register file and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            baud_q    <= '0;
            dev_q     <= '0;
            hold_q    <= 1'b0;
            ie_q      <= 1'b0;
            act_dev_q <= '0;
            hcnt_q    <= '0;
            txn_v_q   <= 1'b0;
            txn_dev_q <= '0;
            irq       <= 1'b0;
            data_q    <= '0;
        end else begin
            if (ctrl_wr) begin
                en_q   <= wr_data[F_EN];
                baud_q <= wr_data[F_BAUD +: BAUD_W];
                dev_q  <= wr_data[F_DEV +: DEV_W];
                hold_q <= wr_data[F_HOLD];
                ie_q   <= wr_data[F_IE];
            end
            txn_v_q   <= ctrl_wr && !hold_q;
            txn_dev_q <= wr_data[F_DEV +: DEV_W];
            if (data_go) begin
                act_dev_q <= dev_q;
                hcnt_q    <= '0;
            end else if (half_tick) begin
                hcnt_q <= hcnt_q + 4'd1;
            end
            irq <= done && ie_q;
            if (done) data_q <= rx_byte;
        end
    end

    assign ctrl_q = {busy, ie_q, hold_q, dev_q, baud_q, en_q};

    spi_half_timer #(.PERIOD_EXP(PERIOD_EXP), .BAUD_W(BAUD_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (timer_run),
        .clr       (data_go),
        .baud      (baud_q),
        .half_tick (half_tick)
    );

    spi_shift_core u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (data_go),
        .load_byte (wr_data),
        .rise      (rise),
        .fall      (fall),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .rx_byte   (rx_byte)
    );

    spi_dev_decode #(.NDEV(NDEV), .SELW(DEV_W)) u_cs_dec (
        .en  (state_q != ST_IDLE),
        .sel (act_dev_q),
        .hit (cs_hit)
    );
    assign cs_n = ~cs_hit;

    spi_dev_decode #(.NDEV(NDEV), .SELW(DEV_W)) u_txn_dec (
        .en  (txn_v_q),
        .sel (txn_dev_q),
        .hit (txn_rst)
    );
endmodule

// File: rtl/spi_byte_host_chk.sv
module spi_byte_host_chk #(
    parameter int NDEV = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            wr_addr,
    input logic [7:0]      ctrl_q,
    input logic [7:0]      data_q,
    input logic            sclk,
    input logic [NDEV-1:0] cs_n,
    input logic [NDEV-1:0] txn_rst,
    input logic            irq
);
    // R2: accepted data write raises busy next cycle
    a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr && ctrl_q[0] && !ctrl_q[7]) |=> ctrl_q[7]);

    // R1: disabled data write leaves busy and data untouched
    a_r1_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr && !ctrl_q[0] && !ctrl_q[7]) |=> (!ctrl_q[7] && $stable(data_q)));

    // R4: irq only right after busy falls and only when enabled
    a_r4_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(ctrl_q[7]) && !ctrl_q[7] && ctrl_q[6]));

    // R5: never more than one chip select low
    a_r5_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R8: restart pulse targets at most one device
    a_r8_single_txn: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(txn_rst));

    // R9: settings frozen while busy
    a_r9_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[7] && $past(ctrl_q[7])) |-> $stable(ctrl_q[6:0]));

    // R10: sclk idles low
    a_r10_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[7] |-> !sclk);
endmodule

bind spi_byte_host spi_byte_host_chk #(.NDEV(NDEV)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .ctrl_q  (ctrl_q),
    .data_q  (data_q),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .txn_rst (txn_rst),
    .irq     (irq)
);

// File: tb/spi_byte_host_tb.sv
module spi_byte_host_tb;
    localparam int K = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] ctrl_q, data_q;
    logic       sclk, mosi, miso;
    logic [2:0] cs_n, txn_rst;
    logic       irq;

    int total = 0;
    int fails = 0;
    int irq_cnt = 0;
    logic [7:0] slave_tx = '0;
    logic [7:0] mosi_cap = '0;
    logic [2:0] rcnt = '0;

    always #5 clk = ~clk;

    spi_byte_host #(.PERIOD_EXP(K), .NDEV(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl_q(ctrl_q), .data_q(data_q), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n), .txn_rst(txn_rst), .irq(irq)
    );

    // device model: mode 0, MSB first
    assign miso = slave_tx[3'd7 - rcnt];
    always @(posedge sclk) begin
        mosi_cap <= {mosi_cap[6:0], mosi};
        rcnt     <= rcnt + 3'd1;
    end
    always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

    function automatic int byte_cycles(input int sp);
        return 1 << (K - sp);
    endfunction
    function automatic int bit_cycles(input int sp);
        return 1 << (K - 3 - sp);
    endfunction
    function automatic logic [2:0] cs_expect(input int dev);
        return (dev < 3) ? ~(3'b001 << dev) : 3'b111;
    endfunction
    function automatic logic [7:0] ctrl_word(input int en, input int sp, input int dev,
                                             input int hold, input int ie);
        return {1'b0, ie[0], hold[0], dev[1:0], sp[1:0], en[0]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // one byte with hold clear; measures busy length and chip-select tail
    task automatic xfer(input int sp, input int dev, input int ie,
                        input logic [7:0] tx, input logic [7:0] rx);
        int n;
        int base;
        base = irq_cnt;
        slave_tx = rx;
        wr(1'b1, tx);
        chk(ctrl_q[7] == 1'b1, "R2 busy set", ctrl_q[7], 1);
        chk(cs_n == cs_expect(dev), "R5 chip select", cs_n, cs_expect(dev));
        n = 0;
        while (ctrl_q[7]) begin n++; @(negedge clk); end
        chk(n == byte_cycles(sp), "R2 busy length", n, byte_cycles(sp));
        chk(data_q == rx, "R3 received byte", data_q, rx);
        chk(mosi_cap == tx, "R3 sent byte", mosi_cap, tx);
        chk(sclk == 1'b0, "R10 sclk idle", sclk, 0);
        if (dev < 3) begin
            n = 0;
            while (cs_n != 3'b111) begin n++; @(negedge clk); end
            chk(n == bit_cycles(sp), "R6 cs tail", n, bit_cycles(sp));
        end else begin
            repeat (2) @(negedge clk);
            chk(cs_n == 3'b111, "R5 no device", cs_n, 7);
        end
        chk(irq_cnt - base == ie, "R4 irq count", irq_cnt - base, ie);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctrl_q == 8'h00, "reset ctrl", ctrl_q, 0);
        chk(data_q == 8'h00, "reset data", data_q, 0);
        chk(cs_n == 3'b111 && irq == 1'b0, "reset outputs", {cs_n, irq}, 4'he);
        chk(sclk == 1'b0, "R10 reset sclk", sclk, 0);

        // R1: disabled write ignored
        wr(1'b0, ctrl_word(0, 3, 1, 0, 1));
        wr(1'b1, 8'hA5);
        repeat (20) @(negedge clk);
        chk(ctrl_q[7] == 1'b0, "R1 busy stays clear", ctrl_q[7], 0);
        chk(data_q == 8'h00, "R1 data unchanged", data_q, 0);
        chk(cs_n == 3'b111 && sclk == 1'b0, "R1 bus idle", {cs_n, sclk}, 4'he);

        // R8: control write while hold clear pulses the new device
        wr(1'b0, ctrl_word(1, 3, 2, 0, 1));
        chk(txn_rst == 3'b100, "R8 restart pulse", txn_rst, 3'b100);
        @(negedge clk);
        chk(txn_rst == 3'b000, "R8 pulse one cycle", txn_rst, 0);

        // directed corner bytes at every speed
        for (int sp = 0; sp < 4; sp++) begin
            wr(1'b0, ctrl_word(1, sp, 2, 0, 1));
            xfer(sp, 2, 1, 8'h80, 8'h01);
        end
        wr(1'b0, ctrl_word(1, 3, 0, 0, 0));
        xfer(3, 0, 0, 8'hFF, 8'h00);
        wr(1'b0, ctrl_word(1, 3, 3, 0, 1));
        xfer(3, 3, 1, 8'h5A, 8'hC3);

        // R9: writes while busy are dropped
        wr(1'b0, ctrl_word(1, 0, 1, 0, 0));
        slave_tx = 8'h3C;
        wr(1'b1, 8'hE7);
        repeat (30) @(negedge clk);
        wr(1'b1, 8'h18);
        wr(1'b0, ctrl_word(0, 3, 2, 1, 1));
        chk(ctrl_q == {1'b1, ctrl_word(1, 0, 1, 0, 0)[6:0]}, "R9 ctrl unchanged",
            ctrl_q, {1'b1, ctrl_word(1, 0, 1, 0, 0)[6:0]});
        chk(txn_rst == 3'b000, "R9 no restart while busy", txn_rst, 0);
        while (ctrl_q[7]) @(negedge clk);
        chk(mosi_cap == 8'hE7, "R9 byte in flight kept", mosi_cap, 8'hE7);
        chk(data_q == 8'h3C, "R9 received kept", data_q, 8'h3C);

        // R6: data write inside the tail restarts with cs still low
        slave_tx = 8'h96;
        wr(1'b1, 8'h69);
        chk(ctrl_q[7] == 1'b1 && cs_n == 3'b101, "R6 restart from tail",
            {ctrl_q[7], cs_n}, 4'hD);
        while (ctrl_q[7]) @(negedge clk);
        chk(mosi_cap == 8'h69 && data_q == 8'h96, "R6 tail byte", {mosi_cap, data_q}, 16'h6996);
        repeat (40) @(negedge clk);

        // R7: held transaction over two bytes
        wr(1'b0, ctrl_word(1, 2, 2, 1, 0));
        chk(txn_rst == 3'b100, "R8 pulse before hold", txn_rst, 3'b100);
        slave_tx = 8'h11;
        wr(1'b1, 8'hA1);
        while (ctrl_q[7]) @(negedge clk);
        repeat (25) @(negedge clk);
        chk(cs_n == 3'b011, "R7 cs held", cs_n, 3'b011);
        slave_tx = 8'h22;
        wr(1'b1, 8'hB2);
        while (ctrl_q[7]) @(negedge clk);
        chk(data_q == 8'h22 && mosi_cap == 8'hB2, "R7 second byte", {data_q, mosi_cap}, 16'h22B2);
        repeat (25) @(negedge clk);
        chk(cs_n == 3'b011, "R7 cs still held", cs_n, 3'b011);
        wr(1'b0, ctrl_word(1, 2, 2, 0, 0));
        chk(txn_rst == 3'b000, "R8 no pulse when hold set", txn_rst, 0);
        chk(cs_n == 3'b111, "R7 release on hold clear", cs_n, 7);

        // constrained random bytes
        void'($urandom(32'd1234));
        for (int i = 0; i < 24; i++) begin
            int sp, dev, ie;
            logic [7:0] tx, rx;
            sp  = int'($urandom_range(3, 0));
            dev = int'($urandom_range(3, 0));
            ie  = int'($urandom_range(1, 0));
            tx  = 8'($urandom);
            rx  = 8'($urandom);
            wr(1'b0, ctrl_word(1, sp, dev, 0, ie));
            chk(txn_rst == ((dev < 3) ? (3'b001 << dev) : 3'b000), "R8 random pulse",
                txn_rst, (dev < 3) ? (1 << dev) : 0);
            xfer(sp, dev, ie, tx, rx);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule